// File: doc/BRIEF.md
# Randomized Channel Scheduler for an Interleaved Converter

This block decides, once per system clock cycle, which sub-converter of an interleaved converter takes the next sample. The converter interleaves by a factor M but has M+1 sub-converters. Each one stays occupied for M system cycles once it starts. Because there is one spare unit, two units are always free when a choice is due. A pseudo-random bit from an on-chip LFSR picks one of them, so the order in which the units are used never settles into a fixed rotation. Any mismatch between units then shows up as spread noise rather than as tones at multiples of fs/M. The combined stream still runs at one sample per system cycle, and each sample comes from exactly one unit.

Each start is marked on a one-hot start vector and labelled with the unit number and a running sequence number. Finished conversions come back on a single return path that carries a valid flag, the unit number and the data. A reorder buffer matches each result to the sequence number its unit was given and releases the data strictly in sampling order, one word per cycle. A result must return between 1 and M-1 cycles after the cycle in which its start was shown. Results may return in a different order from the one in which they were started.

Top module: `rand_il_sched`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `start_o` all zero and `out_valid_o` low.
- R2: In every cycle after the first clock edge with `rst` low, exactly one bit of `start_o` is set.
- R3: A unit whose start bit is shown in cycle t does not have its bit shown again before cycle t+M.
- R4: A unit counts as idle if its bit was not shown in the previous M-1 cycles. The unit started is always one of the two lowest-numbered idle units, and once start-up is over exactly two units are idle at each start.
- R5: The first start after reset goes to unit 0 or unit 1.
- R6: `tag_ch_o` equals the index of the set bit of `start_o`. `tag_seq_o` is 0 on the first start after reset and then rises by 1, modulo 2^SEQ_W, with each start.
- R7: `out_data_o` delivers each returned word exactly once, in the order the samples were started. This holds when results return 1 to M-1 cycles after their start and arrive out of order.
- R8: A result returned in cycle r, with every earlier sample already delivered, appears on `out_data_o` with `out_valid_o` high in cycle r+2.
- R9: Over 10,000 cycles, each unit's share of the starts is within 10% of 1/(M+1).
- R10: The choice is not a fixed rotation. In at least 10% of starts, the unit differs from the one started M+1 cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at the full sample rate |
| rst | input | 1 | Synchronous active-high reset |
| res_valid_i | input | 1 | A sub-converter result is present this cycle |
| res_ch_i | input | CH_W | Unit that produced the result |
| res_data_i | input | DATA_W | Result word |
| start_o | output | M+1 | One-hot sample start, one bit per unit |
| tag_ch_o | output | CH_W | Unit number of the current start |
| tag_seq_o | output | SEQ_W | Sequence number of the current start |
| out_valid_o | output | 1 | Ordered output word present |
| out_data_o | output | DATA_W | Ordered output word |

## Verification
A busy counter that is stuck or off by one shows up as a unit restarted too early (R3), or as a cycle with no start or two starts (R2). Either one is visible within M cycles of the fault. A wrong candidate search picks a unit outside the two lowest idle ones at the very next start, and a fault here usually also breaks R4's count of two. A wrong slot mapping or a wrong read pointer in the reorder buffer shows up a few cycles later as a word out of sequence, or as a missing or repeated word, or as wrong timing (R7, R8). A dead or constant random bit only shows over a long window, as skewed unit shares or a periodic pattern (R9, R10).

// File: rtl/sched_pkg.sv
package sched_pkg;

  // One step of a right-shifting Galois LFSR with the given feedback mask.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s, input logic [15:0] taps);
    return s[0] ? ((s >> 1) ^ taps) : (s >> 1);
  endfunction

endpackage

// File: rtl/sched_lfsr.sv
module sched_lfsr import sched_pkg::*; #(
  parameter logic [15:0] SEED = 16'hACE1,
  parameter logic [15:0] TAPS = 16'hB400
) (
  input  logic clk,
  input  logic rst,
  output logic bit_o
);
  logic [15:0] state;

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= lfsr_step(state, TAPS);
  end

  assign bit_o = state[0];
endmodule

// File: rtl/sched_busy.sv
module sched_busy #(
  parameter int NCH = 5,
  parameter int M   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] load_i,
  output logic [NCH-1:0] idle_o
);
  localparam int CNT_W = (M > 2) ? $clog2(M) : 1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (load_i[g])    cnt <= CNT_W'(M - 1);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
    assign idle_o[g] = (cnt == '0);
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int NCH  = 5,
  parameter int CH_W = 3
) (
  input  logic [NCH-1:0]  idle_i,
  input  logic            sel_i,
  output logic            any_o,
  output logic [CH_W-1:0] id_o,
  output logic [NCH-1:0]  pick_o
);
  logic [CH_W-1:0] c0, c1;
  logic            f0, f1;

  always_comb begin
    c0 = '0; c1 = '0; f0 = 1'b0; f1 = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (idle_i[i]) begin
        if (!f0) begin
          c0 = CH_W'(i); f0 = 1'b1;
        end else if (!f1) begin
          c1 = CH_W'(i); f1 = 1'b1;
        end
      end
    end
    any_o  = f0;
    id_o   = (f1 && sel_i) ? c1 : c0;
    pick_o = f0 ? ({{(NCH-1){1'b0}}, 1'b1} << id_o) : '0;
  end
endmodule

// File: rtl/sched_rob.sv
module sched_rob #(
  parameter int DATA_W = 12,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [AW-1:0]     rd_ptr;
  logic [DEPTH-1:0]  set_m, clr_m;
  logic              head_rdy;

  assign head_rdy = vld[rd_ptr];
  assign set_m    = wr_en_i  ? (DEPTH'(1) << wr_slot_i) : '0;
  assign clr_m    = head_rdy ? (DEPTH'(1) << rd_ptr)    : '0;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_slot_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (head_rdy) out_data_o <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld         <= '0;
      rd_ptr      <= '0;
      out_valid_o <= 1'b0;
    end else begin
      vld         <= (vld | set_m) & ~clr_m;
      out_valid_o <= head_rdy;
      if (head_rdy) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rand_il_sched.sv
module rand_il_sched #(
  parameter int          M         = 4,
  parameter int          DATA_W    = 12,
  parameter int          SEQ_W     = 8,
  parameter int          ROB_AW    = 3,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  localparam int         NCH       = M + 1,
  localparam int         CH_W      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid_i,
  input  logic [CH_W-1:0]   res_ch_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic [NCH-1:0]    start_o,
  output logic [CH_W-1:0]   tag_ch_o,
  output logic [SEQ_W-1:0]  tag_seq_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              rnd_bit;
  logic [NCH-1:0]    idle;
  logic              pick_any;
  logic [CH_W-1:0]   pick_id;
  logic [NCH-1:0]    pick_vec;
  logic [SEQ_W-1:0]  seq_cnt;
  logic [ROB_AW-1:0] slot_of [NCH];
  logic              ret_ok;
  logic [ROB_AW-1:0] ret_slot;

  sched_lfsr #(.SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst(rst), .bit_o(rnd_bit)
  );

  sched_busy #(.NCH(NCH), .M(M)) u_busy (
    .clk(clk), .rst(rst), .load_i(pick_vec), .idle_o(idle)
  );

  sched_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .idle_i(idle), .sel_i(rnd_bit), .any_o(pick_any),
    .id_o(pick_id), .pick_o(pick_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o   <= '0;
      tag_ch_o  <= '0;
      tag_seq_o <= '0;
      seq_cnt   <= '0;
    end else begin
      start_o <= pick_vec;
      if (pick_any) begin
        tag_ch_o  <= pick_id;
        tag_seq_o <= seq_cnt;
        seq_cnt   <= seq_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pick_any) slot_of[pick_id] <= seq_cnt[ROB_AW-1:0];
  end

  assign ret_ok   = res_valid_i && (int'(res_ch_i) < NCH);
  assign ret_slot = ret_ok ? slot_of[res_ch_i] : '0;

  sched_rob #(.DATA_W(DATA_W), .AW(ROB_AW)) u_rob (
    .clk(clk), .rst(rst), .wr_en_i(ret_ok), .wr_slot_i(ret_slot),
    .wr_data_i(res_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );
endmodule

// File: rtl/rand_il_sched_chk.sv
module rand_il_sched_chk #(
  parameter int M     = 4,
  parameter int SEQ_W = 8,
  localparam int NCH  = M + 1,
  localparam int CH_W = $clog2(NCH),
  localparam int GW   = $clog2(M + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   start_o,
  input logic [CH_W-1:0]  tag_ch_o,
  input logic [SEQ_W-1:0] tag_seq_o,
  input logic             out_valid_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (start_o == '0 && !out_valid_o));

  // R2
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($countones(start_o) == 1));

  // R6
  tag_matches_start_chk: assert property (@(posedge clk) disable iff (rst)
    (|start_o) |-> start_o[tag_ch_o]);

  // R6
  seq_steps_chk: assert property (@(posedge clk) disable iff (rst)
    (|start_o) |=> (!(|start_o) || tag_seq_o == SEQ_W'($past(tag_seq_o) + 1'b1)));

  for (genvar g = 0; g < NCH; g++) begin : g_gap
    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
      if (rst)                 gap <= GW'(M);
      else if (start_o[g])     gap <= GW'(1);
      else if (gap < GW'(M))   gap <= gap + 1'b1;
    end
    // R3
    no_early_restart_chk: assert property (@(posedge clk) disable iff (rst)
      start_o[g] |-> (gap >= GW'(M)));
  end
endmodule

bind rand_il_sched rand_il_sched_chk #(.M(M), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst(rst), .start_o(start_o), .tag_ch_o(tag_ch_o),
  .tag_seq_o(tag_seq_o), .out_valid_o(out_valid_o)
);

// File: tb/rand_il_sched_bench.sv
module rand_il_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int M      = 4;
  localparam int NCH    = M + 1;
  localparam int CH_W   = $clog2(NCH);
  localparam int DATA_W = 12;
  localparam int SEQ_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              res_valid = 1'b0;
  logic [CH_W-1:0]   res_ch = '0;
  logic [DATA_W-1:0] res_data = '0;
  logic [NCH-1:0]    start_o;
  logic [CH_W-1:0]   tag_ch_o;
  logic [SEQ_W-1:0]  tag_seq_o;
  logic              out_valid_o;
  logic [DATA_W-1:0] out_data_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rand_il_sched u_rand_il_sched (
    .clk(clk), .rst(rst), .res_valid_i(res_valid), .res_ch_i(res_ch),
    .res_data_i(res_data), .start_o(start_o), .tag_ch_o(tag_ch_o),
    .tag_seq_o(tag_seq_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ret_lat(input int mode, input int fixed_lat, input int seq);
    if (mode == 0) return fixed_lat;
    return (seq % 2 == 0) ? M - 1 : M - 3;
  endfunction

  function automatic int bits_set(input logic [NCH-1:0] v);
    int n = 0;
    for (int i = 0; i < NCH; i++) n += int'(v[i]);
    return n;
  endfunction

  int last_start [NCH];
  int use_cnt    [NCH];
  int exp_q[$];
  int st_q[$];
  int ch_hist[$];
  int ret_ch  [int];
  int ret_dat [int];

  // mode 0: every result returns after fixed_lat; mode 1: latency alternates by sequence parity
  task automatic run_phase(input int ncyc, input int mode, input int fixed_lat,
                           input bit long_checks);
    int exp_seq = 0;
    int mism = 0;
    rst = 1'b1;
    res_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(start_o == '0, "R1", "start_o in reset", int'(start_o), 0);
    chk(!out_valid_o, "R1", "out_valid_o in reset", int'(out_valid_o), 0);
    for (int i = 0; i < NCH; i++) begin
      last_start[i] = -1000;
      use_cnt[i] = 0;
    end
    exp_q.delete(); st_q.delete(); ch_hist.delete();
    ret_ch.delete(); ret_dat.delete();
    rst = 1'b0;
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk);
      #1;
      chk(bits_set(start_o) == 1, "R2", "start bits set", bits_set(start_o), 1);
      if (bits_set(start_o) == 1) begin
        int c = 0;
        int nidle = 0;
        int cand0 = -1;
        int cand1 = -1;
        int d;
        int l;
        for (int i = 0; i < NCH; i++) if (start_o[i]) c = i;
        chk(int'(tag_ch_o) == c, "R6", "tag_ch_o", int'(tag_ch_o), c);
        chk(int'(tag_seq_o) == exp_seq % (1 << SEQ_W), "R6", "tag_seq_o",
            int'(tag_seq_o), exp_seq % (1 << SEQ_W));
        chk(k - last_start[c] >= M, "R3", "cycles since previous start",
            k - last_start[c], M);
        for (int i = 0; i < NCH; i++) begin
          if (k - last_start[i] >= M) begin
            nidle++;
            if (cand0 < 0) cand0 = i;
            else if (cand1 < 0) cand1 = i;
          end
        end
        chk(c == cand0 || c == cand1, "R4", "unit chosen vs lowest idle", c, cand0);
        if (k >= M) chk(nidle == 2, "R4", "idle units at start", nidle, 2);
        if (k == 0) chk(c <= 1, "R5", "first unit after reset", c, 1);
        if (ch_hist.size() >= NCH && ch_hist[ch_hist.size() - NCH] != c) mism++;
        ch_hist.push_back(c);
        d = int'($urandom % (1 << DATA_W));
        exp_q.push_back(d);
        st_q.push_back(k);
        l = ret_lat(mode, fixed_lat, exp_seq);
        chk(!ret_ch.exists(k + l), "R7", "return slot free in stimulus", k + l, -1);
        ret_ch[k + l] = c;
        ret_dat[k + l] = d;
        use_cnt[c]++;
        last_start[c] = k;
        exp_seq++;
      end
      if (out_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "output with nothing outstanding", int'(out_data_o), -1);
        end else begin
          int d = exp_q.pop_front();
          int st = st_q.pop_front();
          chk(int'(out_data_o) == d, "R7", "ordered output word", int'(out_data_o), d);
          if (mode == 0)
            chk(k == st + fixed_lat + 2, "R8", "output cycle", k, st + fixed_lat + 2);
        end
      end
      if (ret_ch.exists(k)) begin
        res_valid = 1'b1;
        res_ch    = CH_W'(ret_ch[k]);
        res_data  = DATA_W'(ret_dat[k]);
      end else begin
        res_valid = 1'b0;
      end
    end
    chk(exp_q.size() <= M + 3, "R7", "words still outstanding", exp_q.size(), M + 3);
    if (long_checks) begin
      for (int i = 0; i < NCH; i++) begin
        chk(use_cnt[i] * NCH * 10 >= ncyc * 9 && use_cnt[i] * NCH * 10 <= ncyc * 11,
            "R9", "unit usage count", use_cnt[i], ncyc / NCH);
      end
      chk(mism * 10 >= ncyc, "R10", "starts differing from M+1 earlier", mism, ncyc / 10);
    end
    res_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_phase(10000, 0, M - 1, 1'b1);
    run_phase(2000, 0, 1, 1'b0);
    run_phase(2000, 1, 0, 1'b0);
    run_phase(3000, 1, 0, 1'b1);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule